// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block translates virtual addresses to physical addresses through a small fully associative table. Each table slot describes two neighbouring virtual pages (an even half and an odd half) that share one tag, one address-space tag and one page-size mask. Each half has its own physical frame and its own permission bits. The page size can differ from slot to slot. The span of a page pair is never smaller than a fixed minimum, set by `PAIR_LSB`.

A request carries a virtual address, the current address-space tag and an access kind. The block searches every slot in parallel and keeps the lowest-numbered hit. It then checks the chosen half's valid, execute-inhibit, read-inhibit and dirty bits, in that order. One cycle later it returns a result code, the physical address and a write-permission flag. Slots are loaded through a plain indexed write port. Refill policy and replacement choice are left to the surrounding logic.

Top module: `tlbx_xlate`

## Requirements
- R1: A response appears on `rsp_valid` exactly one clock after `req_valid` is sampled high. `rsp_valid` is low in every cycle that does not follow a request.
- R2: A slot hits when its hardware-invalidate bit is clear, its global bit is set or its stored address-space tag equals `req_asid`, and the address agrees with the stored tag in every bit outside the comparison mask.
- R3: The comparison mask is the slot's page mask ORed with ones in bits `PAIR_LSB-1`..0. The half is odd when the highest set bit of that mask is set in the address. On result code 0, `rsp_pa` is that half's frame ORed with the address bits below the highest mask bit.
- R4: If the selected half's valid bit is clear, the code is 2 (invalid) for every access kind. This check comes before all others.
- R5: A fetch (`req_kind` 0) to a half with execute-inhibit set gives code 5. Loads and stores are not affected by execute-inhibit.
- R6: A load (`req_kind` 1) to a half with read-inhibit set gives code 4. Fetches and stores are not affected by read-inhibit.
- R7: A store (`req_kind` 2) to a half whose dirty bit is clear gives code 3. On code 0, `rsp_wr_ok` equals the half's dirty bit. For every other code, `rsp_pa` and `rsp_wr_ok` are zero.
- R8: When no slot hits, the code is 1 (no-match).
- R9: When several slots hit, the slot with the lowest index supplies the result.
- R10: After reset every slot is invalidated, so every lookup returns code 1. A write with `wr_en` high replaces slot `wr_idx` in full at the next edge. The per-half flag vectors use bit 0 valid, bit 1 dirty, bit 2 read-inhibit and bit 3 execute-inhibit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one slot |
| wr_idx | input | $clog2(ENTRIES) | Slot to write |
| wr_vpn | input | VA_W | Virtual tag of the page pair |
| wr_pmask | input | VA_W | Page mask (contiguous ones above PAIR_LSB-1) |
| wr_asid | input | ASID_W | Address-space tag |
| wr_global | input | 1 | Ignore the address-space tag |
| wr_hinv | input | 1 | Hardware-invalidate: slot never hits |
| wr_pfn_even | input | PA_W | Frame for the even half |
| wr_pfn_odd | input | PA_W | Frame for the odd half |
| wr_flags_even | input | 4 | Even-half flags {xi, ri, dirty, valid} |
| wr_flags_odd | input | 4 | Odd-half flags {xi, ri, dirty, valid} |
| req_valid | input | 1 | Lookup request |
| req_va | input | VA_W | Virtual address |
| req_asid | input | ASID_W | Current address-space tag |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store |
| rsp_valid | output | 1 | Response strobe |
| rsp_pa | output | PA_W | Physical address |
| rsp_wr_ok | output | 1 | Write permitted |
| rsp_code | output | 3 | 0 match, 1 no-match, 2 invalid, 3 modified, 4 read-inhibit, 5 execute-inhibit |

## Verification
The assertions check several properties on every cycle:
- the one-cycle response timing;
- that the priority picker selects at most one slot, and only a slot that actually hit;
- that each inhibit or modified code is returned only for the access kind that can cause it;
- that failed lookups return a zero address and deny writes.

Other properties can only be shown by the bench's scenarios:
- the correct frame and offset for several page sizes;
- the even/odd half choice;
- the effect of the global bit and the address-space tag;
- invalid taking precedence over the other checks;
- lowest-index priority when two slots hit.

The bench covers these with directed cases and with a randomized sweep checked against its own arithmetic model.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
  localparam int FLAG_W = 4;
  localparam int FL_VALID = 0;
  localparam int FL_DIRTY = 1;
  localparam int FL_RINH  = 2;
  localparam int FL_XINH  = 3;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_kind_e;

  typedef enum logic [2:0] {
    RES_MATCH  = 3'd0,
    RES_NOHIT  = 3'd1,
    RES_INVAL  = 3'd2,
    RES_MOD    = 3'd3,
    RES_RINH   = 3'd4,
    RES_XINH   = 3'd5
  } res_code_e;
endpackage

// File: rtl/tlbx_first_pick.sv
module tlbx_first_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0] hits,
  output logic [N-1:0] pick,
  output logic         any
);
  always_comb begin
    logic found;
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < N; i++) begin
      if (hits[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
    any = found;
  end
endmodule

// File: rtl/tlbx_slot.sv
module tlbx_slot
  import tlbx_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int PA_W     = 32,
  parameter int ASID_W   = 8,
  parameter int PAIR_LSB = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [VA_W-1:0]   wr_vpn,
  input  logic [VA_W-1:0]   wr_pmask,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic              wr_hinv,
  input  logic [PA_W-1:0]   wr_pfn_even,
  input  logic [PA_W-1:0]   wr_pfn_odd,
  input  logic [FLAG_W-1:0] wr_flags_even,
  input  logic [FLAG_W-1:0] wr_flags_odd,
  input  logic [VA_W-1:0]   va,
  input  logic [ASID_W-1:0] asid,
  output logic              hit,
  output logic [PA_W-1:0]   sel_pfn,
  output logic [FLAG_W-1:0] sel_flags,
  output logic [VA_W-1:0]   off_mask
);
  localparam logic [VA_W-1:0] MIN_LOW = {{(VA_W-PAIR_LSB){1'b0}}, {PAIR_LSB{1'b1}}};

  logic [VA_W-1:0]   vpn_q, pmask_q;
  logic [ASID_W-1:0] asid_q;
  logic              glob_q, hinv_q;
  logic [PA_W-1:0]   pfn0_q, pfn1_q;
  logic [FLAG_W-1:0] fl0_q, fl1_q;

  function automatic logic [VA_W-1:0] pair_mask(input logic [VA_W-1:0] pm);
    return pm | MIN_LOW;
  endfunction

  function automatic logic odd_half(input logic [VA_W-1:0] m, input logic [VA_W-1:0] a);
    return |(a & m & ~(m >> 1));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vpn_q <= '0; pmask_q <= '0; asid_q <= '0; glob_q <= 1'b0;
      hinv_q <= 1'b1; pfn0_q <= '0; pfn1_q <= '0; fl0_q <= '0; fl1_q <= '0;
    end else if (wr) begin
      vpn_q <= wr_vpn; pmask_q <= wr_pmask; asid_q <= wr_asid;
      glob_q <= wr_global; hinv_q <= wr_hinv;
      pfn0_q <= wr_pfn_even; pfn1_q <= wr_pfn_odd;
      fl0_q <= wr_flags_even; fl1_q <= wr_flags_odd;
    end
  end

  logic [VA_W-1:0] cmp_mask;
  logic            tag_eq, asid_ok, is_odd;

  always_comb begin
    cmp_mask  = pair_mask(pmask_q);
    tag_eq    = ((va & ~cmp_mask) == (vpn_q & ~cmp_mask));
    asid_ok   = glob_q || (asid_q == asid);
    hit       = asid_ok && tag_eq && !hinv_q;
    is_odd    = odd_half(cmp_mask, va);
    sel_pfn   = is_odd ? pfn1_q : pfn0_q;
    sel_flags = is_odd ? fl1_q : fl0_q;
    off_mask  = cmp_mask >> 1;
  end
endmodule

// File: rtl/tlbx_xlate.sv
module tlbx_xlate
  import tlbx_pkg::*;
#(
  parameter int ENTRIES  = 8,
  parameter int VA_W     = 32,
  parameter int PA_W     = 32,
  parameter int ASID_W   = 8,
  parameter int PAIR_LSB = 13
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(ENTRIES)-1:0] wr_idx,
  input  logic [VA_W-1:0]            wr_vpn,
  input  logic [VA_W-1:0]            wr_pmask,
  input  logic [ASID_W-1:0]          wr_asid,
  input  logic                       wr_global,
  input  logic                       wr_hinv,
  input  logic [PA_W-1:0]            wr_pfn_even,
  input  logic [PA_W-1:0]            wr_pfn_odd,
  input  logic [3:0]                 wr_flags_even,
  input  logic [3:0]                 wr_flags_odd,
  input  logic                       req_valid,
  input  logic [VA_W-1:0]            req_va,
  input  logic [ASID_W-1:0]          req_asid,
  input  logic [1:0]                 req_kind,
  output logic                       rsp_valid,
  output logic [PA_W-1:0]            rsp_pa,
  output logic                       rsp_wr_ok,
  output logic [2:0]                 rsp_code
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] hit_vec, pick_vec;
  logic               any_hit;
  logic [PA_W-1:0]    slot_pfn  [ENTRIES];
  logic [FLAG_W-1:0]  slot_fl   [ENTRIES];
  logic [VA_W-1:0]    slot_off  [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    tlbx_slot #(.VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W), .PAIR_LSB(PAIR_LSB)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .wr(wr_en && (wr_idx == IDX_W'(g))),
      .wr_vpn(wr_vpn), .wr_pmask(wr_pmask), .wr_asid(wr_asid),
      .wr_global(wr_global), .wr_hinv(wr_hinv),
      .wr_pfn_even(wr_pfn_even), .wr_pfn_odd(wr_pfn_odd),
      .wr_flags_even(wr_flags_even), .wr_flags_odd(wr_flags_odd),
      .va(req_va), .asid(req_asid),
      .hit(hit_vec[g]), .sel_pfn(slot_pfn[g]), .sel_flags(slot_fl[g]),
      .off_mask(slot_off[g])
    );
  end

  tlbx_first_pick #(.N(ENTRIES)) u_pick (.hits(hit_vec), .pick(pick_vec), .any(any_hit));

  logic [PA_W-1:0]   win_pfn;
  logic [FLAG_W-1:0] win_fl;
  logic [VA_W-1:0]   win_off;

  always_comb begin
    win_pfn = '0; win_fl = '0; win_off = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      win_pfn = win_pfn | (slot_pfn[i] & {PA_W{pick_vec[i]}});
      win_fl  = win_fl  | (slot_fl[i]  & {FLAG_W{pick_vec[i]}});
      win_off = win_off | (slot_off[i] & {VA_W{pick_vec[i]}});
    end
  end

  function automatic res_code_e classify(input logic hit, input logic [FLAG_W-1:0] fl,
                                         input logic [1:0] kind);
    if (!hit)                                  return RES_NOHIT;
    if (!fl[FL_VALID])                         return RES_INVAL;
    if (kind == ACC_FETCH && fl[FL_XINH])      return RES_XINH;
    if (kind == ACC_LOAD  && fl[FL_RINH])      return RES_RINH;
    if (kind == ACC_STORE && !fl[FL_DIRTY])    return RES_MOD;
    return RES_MATCH;
  endfunction

  res_code_e       code_c;
  logic [PA_W-1:0] pa_c;
  logic            wok_c;

  always_comb begin
    code_c = classify(any_hit, win_fl, req_kind);
    pa_c   = (code_c == RES_MATCH) ? (win_pfn | PA_W'(req_va & win_off)) : '0;
    wok_c  = (code_c == RES_MATCH) && win_fl[FL_DIRTY];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_pa <= '0; rsp_wr_ok <= 1'b0; rsp_code <= RES_NOHIT;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_pa <= pa_c; rsp_wr_ok <= wok_c; rsp_code <= code_c;
      end
    end
  end

  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R1
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R9
  pick_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_vec) && ((pick_vec & ~hit_vec) == '0) && (any_hit == (hit_vec != '0)));
  // R5
  xinh_fetch_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == RES_XINH) |-> $past(req_kind) == ACC_FETCH);
  // R6
  rinh_load_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == RES_RINH) |-> $past(req_kind) == ACC_LOAD);
  // R7
  mod_store_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == RES_MOD) |-> $past(req_kind) == ACC_STORE);
  // R7
  fail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code != RES_MATCH) |-> (rsp_pa == '0 && !rsp_wr_ok));
endmodule

// File: tb/sim_tlbx_xlate.sv
module sim_tlbx_xlate;
  localparam int N = 8;
  localparam int PAIR_LSB = 13;
  localparam logic [31:0] MINLOW = (32'd1 << PAIR_LSB) - 32'd1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [31:0] wr_vpn = '0, wr_pmask = '0, wr_pfn_even = '0, wr_pfn_odd = '0;
  logic [7:0]  wr_asid = '0;
  logic        wr_global = 1'b0, wr_hinv = 1'b0;
  logic [3:0]  wr_flags_even = '0, wr_flags_odd = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic [7:0]  req_asid = '0;
  logic [1:0]  req_kind = '0;
  logic        rsp_valid, rsp_wr_ok;
  logic [31:0] rsp_pa;
  logic [2:0]  rsp_code;

  tlbx_xlate u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn),
    .wr_pmask(wr_pmask), .wr_asid(wr_asid), .wr_global(wr_global), .wr_hinv(wr_hinv),
    .wr_pfn_even(wr_pfn_even), .wr_pfn_odd(wr_pfn_odd),
    .wr_flags_even(wr_flags_even), .wr_flags_odd(wr_flags_odd),
    .req_valid(req_valid), .req_va(req_va), .req_asid(req_asid), .req_kind(req_kind),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_wr_ok(rsp_wr_ok), .rsp_code(rsp_code)
  );

  int checks = 0, fails = 0;

  // behavioural model of the table
  logic [31:0] m_vpn[N], m_pm[N], m_pfn0[N], m_pfn1[N];
  logic [7:0]  m_asid[N];
  logic        m_g[N], m_hinv[N];
  logic [3:0]  m_f0[N], m_f1[N];

  task automatic check(string rq, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // arithmetic view: pair span = mask+1, half = upper half of span
  task automatic model(input logic [31:0] va, input logic [7:0] asid, input logic [1:0] kind,
                       output int code, output logic [31:0] pa, output logic wok);
    code = 1; pa = 0; wok = 0;
    for (int i = 0; i < N; i++) begin
      longint span, half;
      logic [3:0] f;
      if (m_hinv[i] || !(m_g[i] || m_asid[i] == asid)) continue;
      span = longint'(m_pm[i] | MINLOW) + 1;
      if ((longint'(va) / span) != (longint'(m_vpn[i]) / span)) continue;
      half = span / 2;
      f = ((longint'(va) % span) >= half) ? m_f1[i] : m_f0[i];
      if (!f[0]) code = 2;
      else if (kind == 0 && f[3]) code = 5;
      else if (kind == 1 && f[2]) code = 4;
      else if (kind == 2 && !f[1]) code = 3;
      else begin
        code = 0;
        wok = f[1];
        pa = (((longint'(va) % span) >= half) ? m_pfn1[i] : m_pfn0[i])
             | 32'(longint'(va) % half);
      end
      return;
    end
  endtask

  task automatic put(int idx, logic [31:0] vpn, logic [31:0] pm, logic [7:0] asid, logic g,
                     logic hinv, logic [31:0] p0, logic [31:0] p1, logic [3:0] f0, logic [3:0] f1);
    @(negedge clk);
    wr_en = 1; wr_idx = 3'(idx); wr_vpn = vpn; wr_pmask = pm; wr_asid = asid;
    wr_global = g; wr_hinv = hinv; wr_pfn_even = p0; wr_pfn_odd = p1;
    wr_flags_even = f0; wr_flags_odd = f1;
    m_vpn[idx] = vpn; m_pm[idx] = pm; m_asid[idx] = asid; m_g[idx] = g; m_hinv[idx] = hinv;
    m_pfn0[idx] = p0; m_pfn1[idx] = p1; m_f0[idx] = f0; m_f1[idx] = f1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic look(string rq, logic [31:0] va, logic [7:0] asid, logic [1:0] kind,
                      int ecode, logic [31:0] epa, logic ewok);
    @(negedge clk);
    req_valid = 1; req_va = va; req_asid = asid; req_kind = kind;
    @(negedge clk);
    req_valid = 0;
    check("R1", "rsp_valid", rsp_valid, 1);
    check(rq, "code", rsp_code, ecode);
    check(rq, "pa", rsp_pa, epa);
    check(rq, "wr_ok", rsp_wr_ok, ewok);
  endtask

  task automatic look_model(string rq, logic [31:0] va, logic [7:0] asid, logic [1:0] kind);
    int c; logic [31:0] p; logic w;
    model(va, asid, kind, c, p, w);
    look(rq, va, asid, kind, c, p, w);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_vpn[i] = 0; m_pm[i] = 0; m_asid[i] = 0; m_g[i] = 0; m_hinv[i] = 1;
      m_pfn0[i] = 0; m_pfn1[i] = 0; m_f0[i] = 0; m_f1[i] = 0;
    end
    repeat (3) @(negedge clk);
    check("R10", "rsp_valid in reset", rsp_valid, 0);
    rst_n = 1;
    // R10: empty table after reset
    look("R10", 32'h0000_0000, 8'd0, 2'd1, 1, 0, 0);
    look("R10", 32'h1234_5678, 8'd5, 2'd0, 1, 0, 0);
    // R1: idle cycle leaves rsp_valid low
    @(negedge clk);
    check("R1", "rsp_valid idle", rsp_valid, 0);

    // slot 0: 4 KiB pages, asid 5; even valid+dirty, odd valid clean
    put(0, 32'h0001_0000, 32'h0, 8'd5, 0, 0, 32'h8000_0000, 32'h9000_0000, 4'b0011, 4'b0001);
    look("R3", 32'h0001_0123, 8'd5, 2'd1, 0, 32'h8000_0123, 1);
    look("R3", 32'h0001_1456, 8'd5, 2'd1, 0, 32'h9000_0456, 0);
    look("R7", 32'h0001_1456, 8'd5, 2'd2, 3, 0, 0);
    look("R7", 32'h0001_0ABC, 8'd5, 2'd2, 0, 32'h8000_0ABC, 1);
    look("R2", 32'h0001_0123, 8'd6, 2'd1, 1, 0, 0);
    look("R8", 32'h0001_2000, 8'd5, 2'd1, 1, 0, 0);

    // slot 1: 1 MiB pages, global; even invalid, odd xi + dirty
    put(1, 32'h0040_0000, 32'h001F_E000, 8'd0, 1, 0, 32'h0100_0000, 32'h03F0_0000, 4'b0000, 4'b1011);
    look("R4", 32'h0041_2345, 8'd9, 2'd2, 2, 0, 0);
    look("R4", 32'h0041_2345, 8'd9, 2'd0, 2, 0, 0);
    look("R5", 32'h0051_2345, 8'd9, 2'd0, 5, 0, 0);
    look("R5", 32'h0051_2345, 8'd3, 2'd1, 0, 32'h03F1_2345, 1);
    look("R2", 32'h0051_2345, 8'd77, 2'd2, 0, 32'h03F1_2345, 1);

    // slot 2: read-inhibit even half, dirty
    put(2, 32'h0200_0000, 32'h0, 8'd5, 0, 0, 32'h0005_0000, 32'h0006_0000, 4'b0111, 4'b0011);
    look("R6", 32'h0200_0010, 8'd5, 2'd1, 4, 0, 0);
    look("R6", 32'h0200_0010, 8'd5, 2'd0, 0, 32'h0005_0010, 1);
    look("R6", 32'h0200_0010, 8'd5, 2'd2, 0, 32'h0005_0010, 1);

    // slots 3 and 4 overlap: lowest index wins
    put(4, 32'h0300_0000, 32'h0, 8'd5, 0, 0, 32'h4400_0000, 32'h4500_0000, 4'b0011, 4'b0011);
    put(3, 32'h0300_0000, 32'h0, 8'd5, 0, 0, 32'h3300_0000, 32'h3400_0000, 4'b0011, 4'b0011);
    look("R9", 32'h0300_0042, 8'd5, 2'd1, 0, 32'h3300_0042, 1);
    put(3, 32'h0300_0000, 32'h0, 8'd5, 0, 1, 32'h3300_0000, 32'h3400_0000, 4'b0011, 4'b0011);
    look("R9", 32'h0300_1042, 8'd5, 2'd1, 0, 32'h4500_0042, 1);
    look("R2", 32'h0300_1042, 8'd6, 2'd1, 1, 0, 0);

    // slot 5: 64 KiB pages with mixed flags
    put(5, 32'h0500_0000, 32'h0001_E000, 8'd6, 0, 0, 32'h0A00_0000, 32'h0B00_0000, 4'b1101, 4'b0111);

    // randomized sweep against the model (covers R2 R3 R4 R5 R6 R7 R8 R9)
    for (int k = 0; k < 400; k++) begin
      logic [31:0] va;
      int s;
      s = $urandom_range(0, 6);
      va = (s == 6) ? $urandom : (m_vpn[s] ^ ($urandom & 32'h0003_FFFF));
      look_model("R3", va, 8'($urandom_range(4, 7)), 2'($urandom_range(0, 2)));
    end

    // reset clears the table again (R10)
    @(negedge clk); rst_n = 0;
    for (int i = 0; i < N; i++) m_hinv[i] = 1;
    @(negedge clk); rst_n = 1;
    look("R10", 32'h0001_0123, 8'd5, 2'd1, 1, 0, 0);
    finish_run();
  end
endmodule